// File: doc/BRIEF.md
# Lane-Shape Vector Classifier

This block inspects one warp-wide vector of integers, for example a register writeback, and decides whether it has a compact scalar form. A vector whose active lanes all hold one value is *uniform* and reduces to that value. A vector whose lane `i` holds `base + i*stride` is *affine* and reduces to a base and a stride. Any other vector is *generic* and has to be kept lane by lane. A register file placed after this block can keep the short form in place of all the lane values.

The input is a vector qualified by a valid strobe and a per-lane activity mask. Lanes that are masked off play no part in the decision. The class, base and stride are registered and appear one clock after the valid input. The output registers keep their values until the next valid input arrives.

Top module: `vec_shape_classifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `outValid` is 0, `outClass` is 2'b00 and `outBase` and `outStride` are 0.
- R2: Every cycle with `inValid` high produces exactly one cycle of `outValid` high on the next clock, with its result. A cycle with `inValid` low gives `outValid` low on the next clock, and `outClass`, `outBase` and `outStride` keep their previous values.
- R3: When all active lanes hold the same value c, `outClass` is 2'b01 (uniform), `outBase` is c and `outStride` is 0. Lane i is `inData[i*WIDTH +: WIDTH]`.
- R4: When each active lane i holds b + i*s with s not zero, `outClass` is 2'b10 (affine), `outBase` is b and `outStride` is s.
- R5: The affine test, base and stride use WIDTH-bit wrap-around two's-complement arithmetic. Sequences that cross the top of the range, and negative strides, are therefore affine.
- R6: A vector that is neither uniform nor affine gives `outClass` 2'b00 (generic), with `outBase` and `outStride` both 0. The code 2'b11 never appears.
- R7: A vector that fits both tests (stride 0) is always reported as uniform, never as affine.
- R8: A lane whose `inMask` bit is 0 is ignored: its value does not change the class, base or stride.
- R9: With exactly one active lane the result is uniform, with that lane's value as base. With no active lane the result is uniform with base 0.
- R10: The stride comes from the lowest pair of adjacent active lanes (k, k+1), as lane k+1 minus lane k. The base is extrapolated back to lane 0 from the lowest active lane. If there are two or more active lanes, they differ, and no two of them are adjacent, the result is generic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input vector is present this cycle |
| inData | input | LANES*WIDTH | Lane values, lane i at bits [i*WIDTH +: WIDTH] |
| inMask | input | LANES | Lane activity, 1 = lane takes part |
| outValid | output | 1 | Result present this cycle |
| outClass | output | 2 | 00 generic, 01 uniform, 10 affine |
| outBase | output | WIDTH | Uniform value or affine base |
| outStride | output | WIDTH | Affine stride, 0 otherwise |

## Verification
Two results can be true of one vector at once. A vector with stride zero passes both the equality test and the affine test. A masked vector can also be uniform over its active lanes while its inactive lanes hold an affine or random pattern. The bench drives all-equal and all-zero vectors, masked patterns with garbage in the idle lanes, and sparse masks with no adjacent active pair. For each one it computes the expected class by hand from the priority rule (uniform over affine over generic) and compares it with the registered outputs one cycle later. It also runs seeded random affine vectors, some with a corrupted lane, through an independent reference model.

// File: rtl/vshape_pkg.sv
package vshape_pkg;

  typedef enum logic [1:0] {
    CLS_GENERIC = 2'b00,
    CLS_UNIFORM = 2'b01,
    CLS_AFFINE  = 2'b10
  } shapeClass_e;

  // Strobes from control to datapath for one result capture
  typedef struct packed {
    logic load;
    logic capUniform;
    logic capAffine;
  } shapeStrobe_t;

endpackage

// File: rtl/vshape_datapath.sv
module vshape_datapath
  import vshape_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES*WIDTH-1:0] laneData,
  input  logic [LANES-1:0]       laneMask,
  input  shapeStrobe_t           strobe,
  output logic                   allEqual,
  output logic                   affineOk,
  output logic [WIDTH-1:0]       outBase,
  output logic [WIDTH-1:0]       outStride
);

  localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WIDTH-1:0] laneVal [LANES];
  logic [IDXW-1:0]  firstIdx;
  logic [WIDTH-1:0] refVal;
  logic             pairFound;
  logic [WIDTH-1:0] candStride;
  logic [WIDTH-1:0] candBase;
  logic [LANES-1:0] laneEq;
  logic [LANES-1:0] laneFit;

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign laneVal[g] = laneData[g*WIDTH +: WIDTH];
  end

  // Lowest active lane gives the reference value
  always_comb begin
    firstIdx = '0;
    refVal   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (laneMask[i]) begin
        firstIdx = IDXW'(i);
        refVal   = laneVal[i];
      end
    end
  end

  // Lowest adjacent active pair gives the stride
  always_comb begin
    pairFound  = 1'b0;
    candStride = '0;
    for (int i = LANES - 2; i >= 0; i--) begin
      if (laneMask[i] && laneMask[i+1]) begin
        pairFound  = 1'b1;
        candStride = laneVal[i+1] - laneVal[i];
      end
    end
  end

  assign candBase = refVal - WIDTH'(firstIdx) * candStride;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_test
    localparam logic [WIDTH-1:0] LANE_IDX = WIDTH'(g);
    assign laneEq[g]  = !laneMask[g] || (laneVal[g] == refVal);
    assign laneFit[g] = !laneMask[g] ||
                        (laneVal[g] == candBase + LANE_IDX * candStride);
  end

  assign allEqual = &laneEq;
  assign affineOk = pairFound && (&laneFit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outBase   <= '0;
      outStride <= '0;
    end else if (strobe.load) begin
      outBase   <= strobe.capUniform ? refVal :
                   strobe.capAffine  ? candBase : '0;
      outStride <= strobe.capAffine ? candStride : '0;
    end
  end

  // R3: a uniform capture leaves a zero stride
  p_uniform_zero_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.capUniform) |=> (outStride == '0));

  // R6: a generic capture clears base and stride
  p_generic_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && !strobe.capUniform && !strobe.capAffine)
      |=> (outBase == '0 && outStride == '0));

  // R2: without a load the result registers hold
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> ($stable(outBase) && $stable(outStride)));

endmodule

// File: rtl/vshape_ctrl.sv
module vshape_ctrl
  import vshape_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         allEqual,
  input  logic         affineOk,
  output shapeStrobe_t strobe,
  output logic         outValid,
  output shapeClass_e  outClass
);

  always_comb begin
    strobe.load       = inValid;
    strobe.capUniform = inValid && allEqual;
    strobe.capAffine  = inValid && !allEqual && affineOk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outClass <= CLS_GENERIC;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outClass <= strobe.capUniform ? CLS_UNIFORM :
                    strobe.capAffine  ? CLS_AFFINE  : CLS_GENERIC;
      end
    end
  end

  // R2: each valid input yields a valid result next cycle
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R2: no input, no result
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R2: class holds between results
  p_class_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(outClass));

  // R7: never both capture kinds at once
  p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.capUniform, strobe.capAffine}));

  // R7: an all-equal vector wins over affine
  p_uniform_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && allEqual) |=> (outClass == CLS_UNIFORM));

endmodule

// File: rtl/vec_shape_classifier.sv
module vec_shape_classifier
  import vshape_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  logic [LANES*WIDTH-1:0] inData,
  input  logic [LANES-1:0]       inMask,
  output logic                   outValid,
  output logic [1:0]             outClass,
  output logic [WIDTH-1:0]       outBase,
  output logic [WIDTH-1:0]       outStride
);

  shapeStrobe_t strobe;
  shapeClass_e  classReg;
  logic         allEqual;
  logic         affineOk;

  vshape_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .allEqual (allEqual),
    .affineOk (affineOk),
    .strobe   (strobe),
    .outValid (outValid),
    .outClass (classReg)
  );

  vshape_datapath #(.LANES(LANES), .WIDTH(WIDTH)) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .laneData  (inData),
    .laneMask  (inMask),
    .strobe    (strobe),
    .allEqual  (allEqual),
    .affineOk  (affineOk),
    .outBase   (outBase),
    .outStride (outStride)
  );

  assign outClass = classReg;

  // R6: the unused class code never appears
  p_class_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outClass != 2'b11);

  // R3: a uniform result carries zero stride
  p_uniform_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outClass == 2'b01) |-> (outStride == '0));

endmodule

// File: tb/vec_shape_classifier_bench.sv
`timescale 1ns/1ps
module vec_shape_classifier_bench;

  localparam int N = 8;
  localparam int W = 16;

  typedef struct {
    logic         valid;
    logic [1:0]   cls;
    logic [W-1:0] base;
    logic [W-1:0] stride;
    string        tag;
  } expItem_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           inValid = 1'b0;
  logic [N*W-1:0] inData = '0;
  logic [N-1:0]   inMask = '0;
  logic           outValid;
  logic [1:0]     outClass;
  logic [W-1:0]   outBase;
  logic [W-1:0]   outStride;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  expItem_t expQ[$];
  expItem_t lastRes;

  always #2 clk = ~clk;

  vec_shape_classifier u_vec_shape_classifier (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData),
    .inMask(inMask), .outValid(outValid), .outClass(outClass),
    .outBase(outBase), .outStride(outStride)
  );

  function automatic logic [N*W-1:0] mkAff(logic [W-1:0] b, logic [W-1:0] s);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = b + W'(i) * s;
    return v;
  endfunction

  // Independent reference for random vectors
  function automatic expItem_t refModel(logic [N*W-1:0] d, logic [N-1:0] m);
    expItem_t e;
    logic [W-1:0] v0, s, b;
    int f, k;
    bit same, fits;
    e.valid = 1'b1; e.tag = "R10";
    f = -1; k = -1;
    for (int i = 0; i < N; i++) if (m[i] && f < 0) f = i;
    for (int i = 0; i < N - 1; i++) if (m[i] && m[i+1] && k < 0) k = i;
    v0 = (f < 0) ? '0 : d[f*W +: W];
    same = 1'b1;
    for (int i = 0; i < N; i++) if (m[i] && d[i*W +: W] != v0) same = 1'b0;
    if (same) begin
      e.cls = 2'b01; e.base = v0; e.stride = '0; return e;
    end
    e.cls = 2'b00; e.base = '0; e.stride = '0;
    if (k < 0) return e;
    s = d[(k+1)*W +: W] - d[k*W +: W];
    b = v0 - W'(f) * s;
    fits = 1'b1;
    for (int i = 0; i < N; i++) if (m[i] && d[i*W +: W] != b + W'(i) * s) fits = 1'b0;
    if (fits) begin e.cls = 2'b10; e.base = b; e.stride = s; end
    return e;
  endfunction

  task automatic drive(logic [N*W-1:0] d, logic [N-1:0] m,
                       logic [1:0] c, logic [W-1:0] b, logic [W-1:0] s, string tag);
    expItem_t e;
    @(negedge clk);
    inValid = 1'b1; inData = d; inMask = m;
    e.valid = 1'b1; e.cls = c; e.base = b; e.stride = s; e.tag = tag;
    expQ.push_back(e);
    lastRes = e;
  endtask

  task automatic driveModel(logic [N*W-1:0] d, logic [N-1:0] m);
    expItem_t e;
    e = refModel(d, m);
    drive(d, m, e.cls, e.base, e.stride, "R4/R8/R10 random");
  endtask

  task automatic idle(int n);
    expItem_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inData = {N{16'hBEEF}}; inMask = '1;
      e = lastRes; e.valid = 1'b0; e.tag = "R2";
      expQ.push_back(e);
    end
  endtask

  // Monitor: one expected item per cycle, sampled 1 ns after the edge
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (outValid !== e.valid ||
            (outClass !== e.cls || outBase !== e.base || outStride !== e.stride)) begin
          fails++;
          $display("FAIL %s: got v=%0b c=%0d b=%h s=%h, expected v=%0b c=%0d b=%h s=%h",
                   e.tag, outValid, outClass, outBase, outStride,
                   e.valid, e.cls, e.base, e.stride);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] d;
    logic [W-1:0] b, s;
    lastRes.valid = 1'b0; lastRes.cls = 2'b00; lastRes.base = '0;
    lastRes.stride = '0; lastRes.tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    checks++;
    if (outValid !== 1'b0 || outClass !== 2'b00 || outBase !== '0 || outStride !== '0) begin
      fails++;
      $display("FAIL R1: got v=%0b c=%0d b=%h s=%h, expected all zero",
               outValid, outClass, outBase, outStride);
    end

    drive({N{16'd5}}, '1, 2'b01, 16'd5, 16'd0, "R3 all fives");
    drive(mkAff(16'd8, 16'd1), '1, 2'b10, 16'd8, 16'd1, "R4 8..15");
    drive(mkAff(16'd0, 16'd2), '1, 2'b10, 16'd0, 16'd2, "R4 even");
    drive(mkAff(16'hFFFE, 16'd1), '1, 2'b10, 16'hFFFE, 16'd1, "R5 wrap");
    drive(mkAff(16'd10, 16'hFFFD), '1, 2'b10, 16'd10, 16'hFFFD, "R5 negative stride");
    drive({16'd8, 16'd5, 16'd4, 16'd4, 16'hFFFC, 16'd0, 16'd8, 16'd2}, '1,
          2'b00, 16'd0, 16'd0, "R6 generic");
    drive('0, '1, 2'b01, 16'd0, 16'd0, "R7 zero vector uniform");
    idle(2);

    d = mkAff(16'd8, 16'd1); d[3*W +: W] = 16'hDEAD; d[5*W +: W] = 16'hDEAD;
    drive(d, 8'b1101_0111, 2'b10, 16'd8, 16'd1, "R8 masked garbage");
    d = {N{16'd5}}; d[6*W +: W] = 16'd9;
    drive(d, 8'b1011_1111, 2'b01, 16'd5, 16'd0, "R8 masked odd lane");
    drive(mkAff(16'h7000, 16'h0123), 8'b0001_0000, 2'b01,
          16'h7000 + 16'd4 * 16'h0123, 16'd0, "R9 single lane");
    drive(mkAff(16'd3, 16'd9), '0, 2'b01, 16'd0, 16'd0, "R9 no lane");
    d = mkAff(16'd100, 16'd4); d[0 +: W] = 16'h1111; d[W +: W] = 16'h2222;
    drive(d, 8'b1111_1100, 2'b10, 16'd100, 16'd4, "R10 extrapolated base");
    drive({16'd0, 16'd4, 16'd0, 16'd3, 16'd0, 16'd2, 16'd0, 16'd1}, 8'b0101_0101,
          2'b00, 16'd0, 16'd0, "R10 no adjacent pair");
    drive({N{16'd7}}, 8'b0101_0101, 2'b01, 16'd7, 16'd0, "R10 sparse equal");
    d = mkAff(16'd8, 16'd1); d[7*W +: W] = 16'd0;
    drive(d, '1, 2'b00, 16'd0, 16'd0, "R6 broken last lane");
    idle(3);

    for (int t = 0; t < 60; t++) begin
      b = W'($urandom);
      s = W'($urandom % 5) - 16'd2;
      d = mkAff(b, s);
      if (t % 3 == 0) d[($urandom % N)*W +: W] = W'($urandom);
      driveModel(d, N'($urandom) | N'(t % 2 == 0 ? 8'hFF : 8'h00));
      if (t % 7 == 0) idle(1);
    end
    idle(2);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule